// File: doc/BRIEF.md
# Chained Transmit Command Controller

This block sequences transmissions for a node on a token-passing network. The host can queue up to two "send from buffer page" commands back to back. Each queued page is started on a token arrival while the transmitter is idle, so the second one follows the first without further host action.

The outcome of each transmission is a done flag and an acknowledged flag. This outcome is held in a two-stage status buffer, so a first result stays readable until the host clears it, and a later result waits behind it. A level interrupt follows the visible done flag through an enable bit. After every host clear, the interrupt is forced low for a fixed minimum interval, sized from the clock frequency.

A cancel command drops the oldest queued entry and aborts it if it is on the wire. Enable commands that find the queue full are dropped and latch an overflow flag. The line protocol and the packet RAM are outside the block.

Top module: `tx_chain_ctrl`

## Requirements
- R1: Queued pages are started in the order they were enabled: each start raises `tx_start_o` for one cycle with the page on `tx_page_o`, and the queue holds up to QUEUE_DEPTH (2) entries.
- R2: A start happens only in the cycle after `token_i` is sampled high while no transmission is in progress. A token that arrives during a transmission is ignored, and the next entry waits for a token after the current one completes.
- R3: A `tx_done_i` pulse during a transmission ends it and records a result: done=1, plus ack=`tx_ack_i`. Reset leaves done at 0. Only `clr_tx_irq_i` clears a visible done flag.
- R4: A result that arrives while a done flag is visible is held back. The host clear then loads it into `sts_done_o`/`sts_ack_o` in the same cycle.
- R5: `irq_o` is high while the visible done flag is 1, the enable bit is 1, and no gap is running. It stays high until the clear, and a held-back result raises it again after the gap.
- R6: A clear of a visible done flag forces `irq_o` low for exactly GAP_CYC cycles, where GAP_CYC = ceil(GAP_NS*CLK_MHZ/1000). This is 20 at 100 MHz.
- R7: `tx_irq_en_i`=0 blocks only the interrupt. Status bits are still recorded, and raising the enable bit lets a pending done flag assert `irq_o` at once.
- R8: `sts_ack_o` is only ever 1 together with `sts_done_o`. The ack flag does not drive `irq_o` by itself.
- R9: `dis_tx_i` removes the oldest queued entry, so two cancels remove both. If that entry is being transmitted, `tx_abort_o` pulses for one cycle and no result is recorded.
- R10: An enable command that finds the queue full is dropped and sets `cmd_ovf_o`. The flag stays set until reset.
- R11: While both status stages hold unread results, no new transmission is started, even if a token arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| en_tx_i | input | 1 | Enable-transmit command strobe |
| en_page_i | input | PAGE_W | Buffer page for the enable command |
| dis_tx_i | input | 1 | Cancel-oldest command strobe |
| clr_tx_irq_i | input | 1 | Clear-transmit-interrupt command strobe |
| tx_irq_en_i | input | 1 | Interrupt enable for the done flag |
| token_i | input | 1 | Token-received strobe |
| tx_done_i | input | 1 | Transmission-finished strobe from the line side |
| tx_ack_i | input | 1 | Acknowledge result, valid with tx_done_i |
| tx_start_o | output | 1 | One-cycle start pulse |
| tx_page_o | output | PAGE_W | Page to transmit, valid with tx_start_o |
| tx_abort_o | output | 1 | One-cycle abort pulse for a cancelled active send |
| sts_done_o | output | 1 | Visible done status |
| sts_ack_o | output | 1 | Visible acknowledged status |
| cmd_ovf_o | output | 1 | Sticky queue overflow flag |
| irq_o | output | 1 | Level interrupt |

## Verification
The bench builds the block with CLK_MHZ=100, GAP_NS=200, PAGE_W=4 and QUEUE_DEPTH=2. With these values the inactive gap is 20 cycles, which the bench counts edge by edge. A depth of two puts both queue overflow and the two-results-unread hold-off within a few commands. Start pages are checked in order through a scoreboard. This exposes any reordering caused by cancels, dropped overflow entries or deferred starts.

// File: rtl/tx_chain_pkg.sv
package tx_chain_pkg;

  typedef struct packed {
    logic done;
    logic ack;
  } tx_result_t;

  function automatic int gap_cycles(int gap_ns, int clk_mhz);
    return (gap_ns * clk_mhz + 999) / 1000;
  endfunction

endpackage

// File: rtl/tx_cmd_queue.sv
module tx_cmd_queue #(
  parameter int PAGE_W      = 4,
  parameter int QUEUE_DEPTH = 2,
  localparam int CNT_W      = $clog2(QUEUE_DEPTH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              push_i,
  input  logic [PAGE_W-1:0] push_page_i,
  input  logic              pop_i,
  output logic [PAGE_W-1:0] head_page_o,
  output logic              empty_o,
  output logic              ovf_o
);

  logic [PAGE_W-1:0] slot_q [QUEUE_DEPTH];
  logic [CNT_W-1:0]  count_q;
  logic              full;
  logic              push_ok;
  logic              pop_ok;
  logic [CNT_W-1:0]  wr_idx;

  assign full    = (count_q == CNT_W'(QUEUE_DEPTH));
  assign empty_o = (count_q == '0);
  assign push_ok = push_i && !full;
  assign pop_ok  = pop_i && !empty_o;
  assign wr_idx  = count_q - CNT_W'(pop_ok);
  assign head_page_o = slot_q[0];

  for (genvar i = 0; i < QUEUE_DEPTH; i++) begin : g_slot
    logic [PAGE_W-1:0] shifted;
    if (i + 1 < QUEUE_DEPTH) begin : g_mid
      assign shifted = pop_ok ? slot_q[i+1] : slot_q[i];
    end else begin : g_last
      assign shifted = pop_ok ? '0 : slot_q[i];
    end
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                              slot_q[i] <= '0;
      else if (push_ok && wr_idx == CNT_W'(i))  slot_q[i] <= push_page_i;
      else                                      slot_q[i] <= shifted;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      count_q <= '0;
      ovf_o   <= 1'b0;
    end else begin
      count_q <= count_q + CNT_W'(push_ok) - CNT_W'(pop_ok);
      if (push_i && full) ovf_o <= 1'b1;
    end
  end

  // R10
  ovf_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i && full && !pop_i |=> count_q == CNT_W'(QUEUE_DEPTH));

  // R10
  ovf_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_o |=> ovf_o);

  // R1
  depth_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    count_q <= CNT_W'(QUEUE_DEPTH));

endmodule

// File: rtl/tx_status_buf.sv
module tx_status_buf
  import tx_chain_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cpl_i,
  input  logic cpl_ack_i,
  input  logic clr_i,
  output logic done_o,
  output logic ack_o,
  output logic full_o
);

  tx_result_t vis_q, pend_q, vis_d, pend_d, vis_clr;
  logic       pend_vld_q, pend_vld_d;

  always_comb begin
    vis_clr    = clr_i ? (pend_vld_q ? pend_q : '0) : vis_q;
    pend_vld_d = clr_i ? 1'b0 : pend_vld_q;
    pend_d     = pend_q;
    vis_d      = vis_clr;
    if (cpl_i) begin
      if (!vis_clr.done) begin
        vis_d = '{done: 1'b1, ack: cpl_ack_i};
      end else begin
        pend_d     = '{done: 1'b1, ack: cpl_ack_i};
        pend_vld_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vis_q      <= '0;
      pend_q     <= '0;
      pend_vld_q <= 1'b0;
    end else begin
      vis_q      <= vis_d;
      pend_q     <= pend_d;
      pend_vld_q <= pend_vld_d;
    end
  end

  assign done_o = vis_q.done;
  assign ack_o  = vis_q.ack;
  assign full_o = pend_vld_q;

  // R3
  done_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && !clr_i |=> done_o);

  // R4
  pend_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pend_vld_q && !clr_i |=> pend_vld_q && done_o);

  // R8
  ack_only_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> !ack_o);

endmodule

// File: rtl/tx_irq_gap.sv
module tx_irq_gap #(
  parameter int GAP_CYC = 10,
  localparam int GAP_W  = $clog2(GAP_CYC + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic done_i,
  input  logic en_i,
  input  logic clr_i,
  output logic irq_o
);

  logic [GAP_W-1:0] gap_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               gap_q <= '0;
    else if (clr_i && done_i)  gap_q <= GAP_W'(GAP_CYC);
    else if (gap_q != '0)      gap_q <= gap_q - 1'b1;
  end

  assign irq_o = done_i && en_i && (gap_q == '0);

  // R6
  gap_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i && done_i |=> !irq_o);

  // R5
  irq_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o && !clr_i && en_i |=> irq_o);

endmodule

// File: rtl/tx_chain_ctrl.sv
module tx_chain_ctrl
  import tx_chain_pkg::*;
#(
  parameter int PAGE_W      = 4,
  parameter int QUEUE_DEPTH = 2,
  parameter int CLK_MHZ     = 50,
  parameter int GAP_NS      = 200,
  localparam int GAP_CYC    = gap_cycles(GAP_NS, CLK_MHZ)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_tx_i,
  input  logic [PAGE_W-1:0] en_page_i,
  input  logic              dis_tx_i,
  input  logic              clr_tx_irq_i,
  input  logic              tx_irq_en_i,
  input  logic              token_i,
  input  logic              tx_done_i,
  input  logic              tx_ack_i,
  output logic              tx_start_o,
  output logic [PAGE_W-1:0] tx_page_o,
  output logic              tx_abort_o,
  output logic              sts_done_o,
  output logic              sts_ack_o,
  output logic              cmd_ovf_o,
  output logic              irq_o
);

  logic              active_q;
  logic [PAGE_W-1:0] head_page;
  logic              q_empty;
  logic              sts_full;
  logic              pop, cpl, abort, can_start;

  assign abort     = dis_tx_i && active_q;
  assign cpl       = tx_done_i && active_q && !dis_tx_i;
  assign pop       = cpl || (dis_tx_i && !q_empty);
  assign can_start = token_i && !active_q && !q_empty && !sts_full && !dis_tx_i;

  tx_cmd_queue #(
    .PAGE_W      (PAGE_W),
    .QUEUE_DEPTH (QUEUE_DEPTH)
  ) u_queue (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .push_i      (en_tx_i),
    .push_page_i (en_page_i),
    .pop_i       (pop),
    .head_page_o (head_page),
    .empty_o     (q_empty),
    .ovf_o       (cmd_ovf_o)
  );

  tx_status_buf u_status (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .cpl_i     (cpl),
    .cpl_ack_i (tx_ack_i),
    .clr_i     (clr_tx_irq_i),
    .done_o    (sts_done_o),
    .ack_o     (sts_ack_o),
    .full_o    (sts_full)
  );

  tx_irq_gap #(
    .GAP_CYC (GAP_CYC)
  ) u_irq (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .done_i (sts_done_o),
    .en_i   (tx_irq_en_i),
    .clr_i  (clr_tx_irq_i),
    .irq_o  (irq_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q   <= 1'b0;
      tx_start_o <= 1'b0;
      tx_page_o  <= '0;
      tx_abort_o <= 1'b0;
    end else begin
      tx_start_o <= can_start;
      tx_abort_o <= abort;
      if (can_start) tx_page_o <= head_page;
      if (abort || cpl)   active_q <= 1'b0;
      else if (can_start) active_q <= 1'b1;
    end
  end

  // R2
  start_token_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_start_o |-> $past(token_i));

  // R2
  busy_no_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    active_q && !abort && !cpl |=> !tx_start_o);

  // R11
  hold_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sts_full && !clr_tx_irq_i |=> !tx_start_o);

  // R9
  abort_no_status_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    abort && !sts_done_o && !clr_tx_irq_i |=> !sts_done_o);

endmodule

// File: tb/tb_tx_chain_ctrl.sv
module tb_tx_chain_ctrl;
  localparam int PW  = 4;
  localparam int GAP = 20;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en_tx = 0, dis_tx = 0, clr = 0, irq_en = 1, token = 0, done = 0, ack = 0;
  logic [PW-1:0] en_page = '0;
  logic tx_start, tx_abort, sts_done, sts_ack, ovf, irq;
  logic [PW-1:0] tx_page;

  int checks = 0, errors = 0;
  bit finished = 0;
  logic [PW-1:0] exp_q[$];

  always #5 clk = ~clk;

  tx_chain_ctrl #(.PAGE_W(PW), .QUEUE_DEPTH(2), .CLK_MHZ(100), .GAP_NS(200)) dut (
    .clk_i(clk), .rst_ni(rst_n), .en_tx_i(en_tx), .en_page_i(en_page),
    .dis_tx_i(dis_tx), .clr_tx_irq_i(clr), .tx_irq_en_i(irq_en), .token_i(token),
    .tx_done_i(done), .tx_ack_i(ack), .tx_start_o(tx_start), .tx_page_o(tx_page),
    .tx_abort_o(tx_abort), .sts_done_o(sts_done), .sts_ack_o(sts_ack),
    .cmd_ovf_o(ovf), .irq_o(irq));

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  // monitor: compare every start against the scoreboard
  always @(posedge clk) begin
    #1;
    if (rst_n && tx_start) begin
      if (exp_q.size() == 0) chk("R1 unexpected start", 1, 0);
      else chk("R1 start page order", int'(tx_page), int'(exp_q.pop_front()));
    end
  end

  task automatic expect_start(logic [PW-1:0] p); exp_q.push_back(p); endtask

  task automatic enq(logic [PW-1:0] p);
    en_tx = 1; en_page = p; @(negedge clk); en_tx = 0;
  endtask
  task automatic tok(); token = 1; @(negedge clk); token = 0; endtask
  task automatic fin(logic a); done = 1; ack = a; @(negedge clk); done = 0; ack = 0; endtask
  task automatic clear(); clr = 1; @(negedge clk); clr = 0; endtask
  task automatic cancel(); dis_tx = 1; @(negedge clk); dis_tx = 0; endtask
  task automatic idle(int n); repeat (n) @(negedge clk); endtask

  task automatic measure_gap(string req);
    int n = 0;
    while (irq == 0 && n < 100) begin n++; @(negedge clk); end
    chk(req, n, GAP);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    @(negedge clk); @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R3 reset state
    chk("R3 reset done", sts_done, 0);
    chk("R3 reset ack", sts_ack, 0);
    chk("R5 reset irq", irq, 0);
    chk("R10 reset ovf", ovf, 0);

    // chained pair
    enq(3); enq(5);
    idle(2);
    chk("R2 no start without token", tx_start, 0);
    expect_start(3); tok();
    chk("R1 first start", tx_start, 1);
    tok();
    chk("R2 token while busy ignored", tx_start, 0);
    fin(1);
    chk("R3 done set", sts_done, 1);
    chk("R3 ack set", sts_ack, 1);
    chk("R5 irq raised", irq, 1);
    expect_start(5); tok();
    chk("R2 second start after first done", tx_start, 1);
    fin(0);
    chk("R4 first result kept done", sts_done, 1);
    chk("R4 first result kept ack", sts_ack, 1);
    chk("R5 irq held", irq, 1);
    idle(3);
    chk("R3 done held without clear", sts_done, 1);
    clear();
    chk("R4 second result loaded done", sts_done, 1);
    chk("R4 second result loaded ack", sts_ack, 0);
    chk("R8 ack zero gives no effect on irq gap", irq, 0);
    measure_gap("R6 gap length");
    chk("R5 second irq after gap", irq, 1);
    clear();
    chk("R3 cleared", sts_done, 0);
    chk("R5 irq dropped", irq, 0);
    idle(GAP + 5);

    // overflow and hold-off
    enq(1); enq(2); enq(7);
    chk("R10 overflow flag", ovf, 1);
    expect_start(1); tok(); fin(1);
    expect_start(2); tok(); fin(1);
    tok();
    chk("R10 dropped entry never starts", tx_start, 0);
    enq(9);
    tok();
    chk("R11 hold-off with both results unread", tx_start, 0);
    chk("R10 overflow sticky", ovf, 1);
    clear();
    measure_gap("R6 gap length again");
    expect_start(9); tok();
    chk("R11 start after clear", tx_start, 1);
    fin(0);
    clear();
    idle(GAP + 2);
    chk("R4 third result done", sts_done, 1);
    chk("R4 third result ack", sts_ack, 0);
    clear(); idle(GAP + 2);

    // mask
    irq_en = 0;
    enq(4); expect_start(4); tok(); fin(1);
    chk("R7 status recorded while masked", sts_done, 1);
    chk("R7 irq masked", irq, 0);
    irq_en = 1; #1;
    chk("R7 irq on unmask", irq, 1);
    @(negedge clk);
    clear(); idle(GAP + 2);

    // cancel oldest
    enq(6); enq(8);
    cancel();
    expect_start(8); tok();
    chk("R9 cancel skips oldest", tx_start, 1);
    fin(1); clear(); idle(GAP + 2);
    enq(10); enq(11);
    expect_start(10); tok();
    cancel();
    chk("R9 abort pulse", tx_abort, 1);
    idle(1);
    chk("R9 abort pulse one cycle", tx_abort, 0);
    chk("R9 no status on abort", sts_done, 0);
    expect_start(11); tok();
    cancel();
    chk("R9 second abort", tx_abort, 1);
    tok();
    chk("R9 queue empty after cancels", tx_start, 0);
    enq(12); enq(13);
    cancel(); cancel();
    tok();
    chk("R9 two cancels remove both", tx_start, 0);
    chk("R9 no abort when idle", tx_abort, 0);
    idle(3);
    chk("R1 scoreboard drained", exp_q.size(), 0);
    summary();
  end
endmodule